// File: doc/BRIEF.md
# Two-Pin Interrupt Router with Read-to-Clear Sources

This block gathers the interrupt conditions of a sensor's internal functions and presents them on two interrupt pins. Three sources are sticky events: motion detected, stillness detected and new sample available. A single-cycle pulse sets each of them, and each stays set until the host reads a particular register. The other three sources follow FIFO levels directly: FIFO holds data, FIFO reached its threshold, and FIFO overflowed. They clear by themselves once the host has drained enough data.

Each pin has an 8-bit routing register. Bits 0 to 6 choose the sources that drive the pin, and bit 7 makes the pin active low. A pin with no source chosen has its output enable deasserted. A status vector shows every source at once, so the host can tell which condition raised a pin. The register-read strobe is a plain control input, not a stream: a read is a one-cycle `rd_valid` with `rd_addr`. There is no back-pressure and no handshake. The configuration write port works the same way.

Top module: `irq_route_ctrl`

## Requirements
- R1: During reset and after it, both routing registers read as zero, so both `pin_oe` bits are 0, and all sticky sources are cleared.
- R2: A pulse on `evt_motion`, `evt_still` or `evt_sample` sets status bit 4, 5 or 0 respectively at the next clock edge. The bit then holds until it is cleared.
- R3: A read strobe (`rd_valid`=1) at address 0x0B clears status bits 4 and 5 at the next edge and leaves bit 0 unchanged.
- R4: A read strobe at any address from 0x08 to 0x0A or from 0x0E to 0x15 clears status bit 0 and leaves bits 4 and 5 unchanged. Reads at other addresses clear nothing.
- R5: When a set pulse and its clearing read arrive in the same cycle, the bit ends up set.
- R6: Status bits 1, 2 and 3 equal `lvl_fifo_rdy`, `lvl_fifo_wm` and `lvl_fifo_ovr` in the same cycle, with no storage.
- R7: The active state of a pin is the OR of the status bits selected by bits 0 to 6 of its routing register. Source bit i of the register selects status bit i.
- R8: With bit 7 of a pin's routing register clear, `pin_out` is 1 when the pin is active. With bit 7 set, `pin_out` is 0 when the pin is active and 1 when it is idle.
- R9: `pin_oe` of a pin is 1 exactly when at least one of bits 0 to 6 of its routing register is set. Bit 7 alone does not enable the pin.
- R10: A write (`cfg_we`=1) loads `cfg_wdata` into the routing register of pin `cfg_sel` at the next edge. The other pin's register is not affected.
- R11: Status bit 6 is a spare and always reads 0. Routing only bit 6 enables the pin but never makes it active.
- R12: While `rd_valid` is 0, `rd_addr` has no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Routing register write strobe |
| cfg_sel | input | 1 | Routing register select (0 = pin 0, 1 = pin 1) |
| cfg_wdata | input | 8 | Routing register value; bits 0-6 select sources, bit 7 selects active low |
| rd_valid | input | 1 | Host register read strobe |
| rd_addr | input | 8 | Address of the host read |
| evt_motion | input | 1 | Motion event pulse |
| evt_still | input | 1 | Stillness event pulse |
| evt_sample | input | 1 | New sample event pulse |
| lvl_fifo_rdy | input | 1 | FIFO holds data (level) |
| lvl_fifo_wm | input | 1 | FIFO at or above threshold (level) |
| lvl_fifo_ovr | input | 1 | FIFO overflowed (level) |
| status | output | 7 | Source status, one bit per source in the routing register's bit order |
| pin_out | output | 2 | Driven value of each interrupt pin |
| pin_oe | output | 2 | Output enable of each interrupt pin |

## Verification
A sticky bit held in the wrong state appears on `status` in the first cycle after the pulse or read that should have changed it. If that source is routed to a pin, the fault also reaches `pin_out` in that same cycle. A routing register that loaded wrongly changes `pin_oe` or the pin's polarity one edge after the write. The bench therefore checks every output in every cycle against a model built from the requirements. It does not wait for any later symptom.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int SRC_W   = 7;
  localparam int MAP_W   = 8;
  localparam int POL_BIT = 7;

  // source bit positions, shared by status and routing registers
  localparam int SRC_SAMPLE = 0;
  localparam int SRC_FRDY   = 1;
  localparam int SRC_FWM    = 2;
  localparam int SRC_FOVR   = 3;
  localparam int SRC_MOTION = 4;
  localparam int SRC_STILL  = 5;
  localparam int SRC_SPARE  = 6;

  localparam int N_STICKY = 3;

  typedef logic [SRC_W-1:0] src_vec_t;
  typedef logic [MAP_W-1:0] map_t;
endpackage

// File: rtl/irq_clr_decode.sv
`timescale 1ns/1ps
module irq_clr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] WIN_A_LO  = 8'h08,
  parameter logic [ADDR_W-1:0] WIN_A_HI  = 8'h0A,
  parameter logic [ADDR_W-1:0] WIN_B_LO  = 8'h0E,
  parameter logic [ADDR_W-1:0] WIN_B_HI  = 8'h15
) (
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              clr_motion,
  output logic              clr_sample
);
  logic in_win_a, in_win_b;

  always_comb begin
    in_win_a   = (rd_addr >= WIN_A_LO) && (rd_addr <= WIN_A_HI);
    in_win_b   = (rd_addr >= WIN_B_LO) && (rd_addr <= WIN_B_HI);
    clr_motion = rd_valid && (rd_addr == STAT_ADDR);
    clr_sample = rd_valid && (in_win_a || in_win_b);
  end
endmodule

// File: rtl/irq_sticky_bit.sv
`timescale 1ns/1ps
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear so a coincident event is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_map_reg.sv
`timescale 1ns/1ps
module irq_map_reg
  import irq_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  map_t wdata,
  output map_t map_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  map_q <= '0;
    else if (we) map_q <= wdata;
  end
endmodule

// File: rtl/irq_pin_drive.sv
`timescale 1ns/1ps
module irq_pin_drive
  import irq_route_pkg::*;
(
  input  map_t     map_i,
  input  src_vec_t status_i,
  output logic     pin_o,
  output logic     oe_o
);
  src_vec_t sel;
  logic     active;

  always_comb begin
    sel    = map_i[SRC_W-1:0];
    active = |(sel & status_i);
    pin_o  = active ^ map_i[POL_BIT];
    oe_o   = |sel;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_PINS = 2,
  parameter int ADDR_W = 8,
  localparam int SEL_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [MAP_W-1:0]  cfg_wdata,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              evt_motion,
  input  logic              evt_still,
  input  logic              evt_sample,
  input  logic              lvl_fifo_rdy,
  input  logic              lvl_fifo_wm,
  input  logic              lvl_fifo_ovr,
  output logic [SRC_W-1:0]  status,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe
);
  logic clr_motion, clr_sample;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;

  irq_clr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .clr_motion(clr_motion),
    .clr_sample(clr_sample)
  );

  // sticky slot order: 0 sample, 1 motion, 2 stillness
  always_comb begin
    st_set = {evt_still, evt_motion, evt_sample};
    st_clr = {clr_motion, clr_motion, clr_sample};
  end

  for (genvar s = 0; s < N_STICKY; s++) begin : g_sticky
    irq_sticky_bit u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(st_set[s]),
      .clr_i(st_clr[s]),
      .q_o  (st_q[s])
    );
  end

  always_comb begin
    status             = '0;
    status[SRC_SAMPLE] = st_q[0];
    status[SRC_FRDY]   = lvl_fifo_rdy;
    status[SRC_FWM]    = lvl_fifo_wm;
    status[SRC_FOVR]   = lvl_fifo_ovr;
    status[SRC_MOTION] = st_q[1];
    status[SRC_STILL]  = st_q[2];
    status[SRC_SPARE]  = 1'b0;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    map_t map_q;
    logic wr_this;

    always_comb wr_this = cfg_we && (cfg_sel == SEL_W'(p));

    irq_map_reg u_map (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_this),
      .wdata(cfg_wdata),
      .map_q(map_q)
    );

    irq_pin_drive u_drv (
      .map_i   (map_q),
      .status_i(status),
      .pin_o   (pin_out[p]),
      .oe_o    (pin_oe[p])
    );
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
`timescale 1ns/1ps
module irq_route_ctrl_chk
  import irq_route_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [0:0]       cfg_sel,
  input logic [MAP_W-1:0] cfg_wdata,
  input logic             rd_valid,
  input logic [7:0]       rd_addr,
  input logic             evt_motion,
  input logic             evt_still,
  input logic             evt_sample,
  input logic             lvl_fifo_rdy,
  input logic             lvl_fifo_wm,
  input logic             lvl_fifo_ovr,
  input logic [SRC_W-1:0] status,
  input logic [1:0]       pin_out,
  input logic [1:0]       pin_oe
);
  logic data_win;
  always_comb data_win = ((rd_addr >= 8'h08) && (rd_addr <= 8'h0A)) ||
                         ((rd_addr >= 8'h0E) && (rd_addr <= 8'h15));

  always_comb begin
    if (!rst_n) p_rst_quiet_r1: assert (pin_oe == 2'b00);
  end

  p_motion_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_motion |=> status[SRC_MOTION]);
  p_still_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_still |=> status[SRC_STILL]);
  p_sample_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sample |=> status[SRC_SAMPLE]);
  p_motion_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr == 8'h0B && !evt_motion) |=> !status[SRC_MOTION]);
  p_sample_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && data_win && !evt_sample) |=> !status[SRC_SAMPLE]);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && status[SRC_MOTION]) |=> status[SRC_MOTION]);
  p_fifo_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[SRC_FOVR:SRC_FRDY] == {lvl_fifo_ovr, lvl_fifo_wm, lvl_fifo_rdy});
  p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !status[SRC_SPARE]);

  for (genvar p = 0; p < 2; p++) begin : g_pin_chk
    p_empty_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 1'(p) && cfg_wdata[SRC_W-1:0] == '0) |=> !pin_oe[p]);
    p_pol_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 1'(p) && cfg_wdata == 8'h80) |=> (pin_out[p] && !pin_oe[p]));
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .evt_motion(evt_motion), .evt_still(evt_still), .evt_sample(evt_sample),
  .lvl_fifo_rdy(lvl_fifo_rdy), .lvl_fifo_wm(lvl_fifo_wm),
  .lvl_fifo_ovr(lvl_fifo_ovr), .status(status), .pin_out(pin_out),
  .pin_oe(pin_oe)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic rd_valid = 0;
  logic [7:0] rd_addr = 0;
  logic evt_motion = 0, evt_still = 0, evt_sample = 0;
  logic lvl_fifo_rdy = 0, lvl_fifo_wm = 0, lvl_fifo_ovr = 0;
  logic [6:0] status;
  logic [1:0] pin_out, pin_oe;

  always #2 clk = ~clk;  // 250 MHz

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .evt_motion(evt_motion), .evt_still(evt_still), .evt_sample(evt_sample),
    .lvl_fifo_rdy(lvl_fifo_rdy), .lvl_fifo_wm(lvl_fifo_wm),
    .lvl_fifo_ovr(lvl_fifo_ovr), .status(status), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  typedef struct {
    logic [6:0] st;
    logic [1:0] po;
    logic [1:0] oe;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;

  // reference state, built from the requirements
  logic [7:0] m_map [2];
  logic m_motion = 0, m_still = 0, m_sample = 0;

  function automatic bit in_data_win(logic [7:0] a);
    return (a >= 8'h08 && a <= 8'h0A) || (a >= 8'h0E && a <= 8'h15);
  endfunction

  task automatic drive(input logic we, input logic sel, input logic [7:0] wd,
                       input logic rv, input logic [7:0] ra,
                       input logic em, input logic es, input logic ed,
                       input logic fr, input logic fw, input logic fo,
                       input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    rd_valid = rv; rd_addr = ra;
    evt_motion = em; evt_still = es; evt_sample = ed;
    lvl_fifo_rdy = fr; lvl_fifo_wm = fw; lvl_fifo_ovr = fo;
    if (we) m_map[sel] = wd;
    if (em) m_motion = 1; else if (rv && ra == 8'h0B) m_motion = 0;
    if (es) m_still = 1;  else if (rv && ra == 8'h0B) m_still = 0;
    if (ed) m_sample = 1; else if (rv && in_data_win(ra)) m_sample = 0;
    @(posedge clk);
    #1;
    e.st = {1'b0, m_still, m_motion, fo, fw, fr, m_sample};
    for (int p = 0; p < 2; p++) begin
      e.oe[p] = |m_map[p][6:0];
      e.po[p] = (|(m_map[p][6:0] & e.st)) ^ m_map[p][7];
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 8'h00, 0, 8'h00, 0, 0, 0,
          lvl_fifo_rdy, lvl_fifo_wm, lvl_fifo_ovr, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    drive(0, 0, 8'h00, 1, a, 0, 0, 0,
          lvl_fifo_rdy, lvl_fifo_wm, lvl_fifo_ovr, tag);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input string tag);
    drive(1, sel, d, 0, 8'h00, 0, 0, 0,
          lvl_fifo_rdy, lvl_fifo_wm, lvl_fifo_ovr, tag);
  endtask

  // monitor: pops expectations and compares with the ports
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1.5;
      while (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (status !== e.st || pin_out !== e.po || pin_oe !== e.oe) begin
          n_err++;
          $display("FAIL %s: status=%b pin_out=%b pin_oe=%b expected status=%b pin_out=%b pin_oe=%b",
                   e.tag, status, pin_out, pin_oe, e.st, e.po, e.oe);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_map[0] = 0; m_map[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (pin_oe !== 2'b00 || status !== 7'h00) begin
      n_err++;
      $display("FAIL R1 in reset: pin_oe=%b status=%b expected 00 / 0000000", pin_oe, status);
    end
    @(negedge clk); rst_n = 1;
    idle("R1 after reset");

    // sticky sets
    drive(0,0,0, 0,0, 1,0,0, 0,0,0, "R2 motion set");
    idle("R2 motion holds");
    drive(0,0,0, 0,0, 0,1,1, 0,0,0, "R2 still+sample set");
    // clear-address behaviour
    rd(8'h0C, "R4 addr 0x0C clears nothing");
    rd(8'h0D, "R4 addr 0x0D clears nothing");
    rd(8'h16, "R4 addr 0x16 clears nothing");
    rd(8'h07, "R4 addr 0x07 clears nothing");
    drive(0,0,0, 0,8'h0B, 0,0,0, 0,0,0, "R12 addr without strobe");
    rd(8'h0B, "R3 status read clears motion/still only");
    rd(8'h09, "R4 data window A clears sample");
    drive(0,0,0, 0,0, 0,0,1, 0,0,0, "R2 sample set again");
    rd(8'h15, "R4 data window B upper edge");
    drive(0,0,0, 0,0, 0,0,1, 0,0,0, "R2 sample set");
    rd(8'h0E, "R4 data window B lower edge");
    drive(0,0,0, 0,0, 0,0,1, 0,0,0, "R2 sample set");
    rd(8'h0A, "R4 data window A upper edge");
    // coincident set and clear
    drive(0,0,0, 1,8'h0B, 1,1,0, 0,0,0, "R5 set beats status clear");
    drive(0,0,0, 1,8'h08, 0,0,1, 0,0,0, "R5 set beats data clear");
    rd(8'h0B, "R3 clear after coincident");
    rd(8'h08, "R4 clear after coincident");

    // FIFO levels
    drive(0,0,0, 0,0, 0,0,0, 1,0,0, "R6 fifo ready");
    drive(0,0,0, 0,0, 0,0,0, 1,1,1, "R6 all fifo levels");
    drive(0,0,0, 0,0, 0,0,0, 0,1,0, "R6 fifo drained");
    drive(0,0,0, 0,0, 0,0,0, 0,0,0, "R6 fifo empty");

    // routing and polarity
    wr(0, 8'h80, "R9 polarity alone keeps pin off");
    wr(1, 8'h40, "R11 spare only enables pin1");
    drive(0,0,0, 0,0, 1,0,0, 0,0,0, "R11 spare never active");
    wr(0, 8'h11, "R10 write pin0 leaves pin1");
    wr(1, 8'h06, "R7 map fifo bits to pin1");
    drive(0,0,0, 0,0, 0,0,0, 0,1,0, "R7 OR of mapped sources");
    rd(8'h0B, "R7 motion cleared, pin0 idle");
    wr(0, 8'h91, "R8 active low pin0");
    drive(0,0,0, 0,0, 0,0,1, 0,0,0, "R8 active low asserted");
    rd(8'h08, "R8 active low idle");
    wr(1, 8'hFF, "R9 all sources pin1 active low");
    drive(0,0,0, 0,0, 0,1,0, 0,0,1, "R7 shared source on both pins");
    rd(8'h0B, "R7 still cleared, fifo holds pin1");
    drive(0,0,0, 0,0, 0,0,0, 0,0,0, "R8 pin1 idle high");
    wr(0, 8'h00, "R9 empty map disables pin0");
    wr(1, 8'h00, "R9 empty map disables pin1");

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule